// File: doc/BRIEF.md
# Contiguous Transfer Request Coalescer

The coalescer sits between a producer that posts write requests and a consumer that drains bytes from memory. Each request is a start address and a byte count. The block holds one active span, which the consumer drains, and one waiting span behind it. A new request that starts exactly where the active span ends is folded into the active span, provided no span is waiting. A request that starts exactly where the waiting span ends is folded into the waiting span. Any other request takes the empty waiting slot. If no merge applies and the waiting slot is full, the producer is told to hold.

The consumer sees the address of the next byte to fetch and the number of bytes left in the active span. Each cycle it reports how many bytes it took. When the active span is fully drained, the waiting span moves up with nothing consumed, or the block goes idle. Any agent can ask whether an address is still owed to the consumer. The answer comes from the address ranges held, not from request identifiers.

A producer that has been held for a configurable number of consecutive cycles receives a one-cycle give-up pulse. It then abandons the request and resets the link.

Top module: `xfer_coalescer`

## Requirements
- R1: After reset the block is idle: `active` is 0, `cons_avail` is 0 and `qry_pending` is 0 for every address.
- R2: When idle, a request with nonzero count is acknowledged in the same cycle. From the next cycle it is the active span, with `cons_addr` equal to its start and `cons_avail` equal to its count.
- R3: With no span waiting, a request whose address equals active start plus active count is acknowledged and added to the active count, if the sum fits in LEN_W bits.
- R4: With a span waiting, a request whose address equals waiting start plus waiting count is acknowledged and added to the waiting count, if the sum fits in LEN_W bits.
- R5: A nonzero request that matches no merge rule, arriving while the block is busy and the waiting slot is empty, is acknowledged and stored as the waiting span. This includes a request refused a merge because of overflow.
- R6: When the block is busy, the waiting slot is full and no merge applies, `req_wait` is 1, `req_ack` is 0 and no span changes.
- R7: A consumer report of n bytes takes min(n, `cons_avail`). After the edge, `cons_addr` has advanced and `cons_avail` has dropped by the amount taken.
- R8: When the consumed count reaches the active count, the waiting span becomes active with nothing consumed, or else the block goes idle. A request in that same cycle is classified against the state before the edge and applied before this step.
- R9: `qry_pending` is 1 exactly when `qry_addr` lies in [active start + consumed, active start + active count) or in [waiting start, waiting start + waiting count). Both ranges are taken modulo 2^ADDR_W.
- R10: `req_giveup` is 1 on the TIMEOUT_CYC-th consecutive cycle with `req_wait` high. The stall count then restarts from zero.
- R11: A request with count zero is acknowledged and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Producer presents a request |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | LEN_W | Request byte count |
| req_ack | output | 1 | Request taken this cycle |
| req_wait | output | 1 | Request must be held |
| req_giveup | output | 1 | Stall limit reached; producer abandons |
| cons_valid | input | 1 | Consumer reports bytes taken |
| cons_len | input | LEN_W | Bytes taken this cycle |
| cons_addr | output | ADDR_W | Address of next byte to fetch |
| cons_avail | output | LEN_W | Bytes left in the active span |
| active | output | 1 | An active span exists |
| qry_addr | input | ADDR_W | Address to test |
| qry_pending | output | 1 | Address still owed to the consumer |

## Verification
The assertions assume two things about the inputs. A producer drives no request whose span crosses the top of the address space twice. The consumer's report is meaningful only while `active` is high. The stability and advance properties also assume a request or consumer report sits still when its valid is low. The stimulus keeps spans short relative to the address space, so modular wrap happens only where it is meant to. Stalled requests are sometimes held and sometimes dropped, so both the give-up path and the timer restart are reached.

// File: rtl/xc_pkg.sv
package xc_pkg;

    // Outcome of classifying one incoming request against the held spans
    typedef enum logic [2:0] {
        DEC_NONE     = 3'd0,
        DEC_NULL     = 3'd1,
        DEC_START    = 3'd2,
        DEC_GROW_ACT = 3'd3,
        DEC_GROW_Q   = 3'd4,
        DEC_ENQ      = 3'd5,
        DEC_WAIT     = 3'd6
    } dec_e;

    function automatic logic dec_accepts(dec_e d);
        return (d != DEC_NONE) && (d != DEC_WAIT);
    endfunction

endpackage

// File: rtl/xc_decide.sv
module xc_decide
    import xc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              act_valid,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic [LEN_W-1:0]  act_len,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [LEN_W-1:0]  q_len,
    output dec_e              dec
);
    logic [ADDR_W-1:0] act_end, q_end;
    logic [LEN_W:0]    act_sum, q_sum;
    logic              act_fit, q_fit;

    always_comb begin
        act_end = act_addr + ADDR_W'(act_len);
        q_end   = q_addr + ADDR_W'(q_len);
        act_sum = {1'b0, act_len} + {1'b0, req_len};
        q_sum   = {1'b0, q_len} + {1'b0, req_len};
        act_fit = !act_sum[LEN_W];
        q_fit   = !q_sum[LEN_W];
    end

    always_comb begin
        if (!req_valid)
            dec = DEC_NONE;
        else if (req_len == '0)
            dec = DEC_NULL;
        else if (!act_valid)
            dec = DEC_START;
        else if (!q_valid && req_addr == act_end && act_fit)
            dec = DEC_GROW_ACT;
        else if (q_valid && req_addr == q_end && q_fit)
            dec = DEC_GROW_Q;
        else if (!q_valid)
            dec = DEC_ENQ;
        else
            dec = DEC_WAIT;
    end
endmodule

// File: rtl/xc_slots.sv
module xc_slots
    import xc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_e              dec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              cons_valid,
    input  logic [LEN_W-1:0]  cons_len,
    output logic              act_valid,
    output logic [ADDR_W-1:0] act_addr,
    output logic [LEN_W-1:0]  act_len,
    output logic [LEN_W-1:0]  act_done,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_addr,
    output logic [LEN_W-1:0]  q_len
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } span_t;

    span_t            act_r, q_r, act_n, q_n;
    logic             av_r, qv_r, av_n, qv_n;
    logic [LEN_W-1:0] done_r, done_n, rem, take;

    always_comb begin
        act_n  = act_r;
        q_n    = q_r;
        av_n   = av_r;
        qv_n   = qv_r;
        done_n = done_r;
        rem    = act_r.len - done_r;
        take   = (cons_len > rem) ? rem : cons_len;

        // consumer progress on the span held before this edge
        if (av_r && cons_valid)
            done_n = done_r + take;

        // request outcome, classified against the pre-edge state
        unique case (dec)
            DEC_START: begin
                act_n  = '{base: req_addr, len: req_len};
                done_n = '0;
                av_n   = 1'b1;
            end
            DEC_GROW_ACT: act_n.len = act_r.len + req_len;
            DEC_GROW_Q:   q_n.len   = q_r.len + req_len;
            DEC_ENQ: begin
                q_n  = '{base: req_addr, len: req_len};
                qv_n = 1'b1;
            end
            default: ;
        endcase

        // drained span: promote the waiting one or go idle
        if (av_n && done_n == act_n.len) begin
            done_n = '0;
            if (qv_n) begin
                act_n = q_n;
                qv_n  = 1'b0;
            end else begin
                av_n  = 1'b0;
                act_n = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_r  <= '0;
            q_r    <= '0;
            av_r   <= 1'b0;
            qv_r   <= 1'b0;
            done_r <= '0;
        end else begin
            act_r  <= act_n;
            q_r    <= q_n;
            av_r   <= av_n;
            qv_r   <= qv_n;
            done_r <= done_n;
        end
    end

    assign act_valid = av_r;
    assign act_addr  = act_r.base;
    assign act_len   = act_r.len;
    assign act_done  = done_r;
    assign q_valid   = qv_r;
    assign q_addr    = q_r.base;
    assign q_len     = q_r.len;
endmodule

// File: rtl/xc_query.sv
module xc_query #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              act_valid,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic [LEN_W-1:0]  act_len,
    input  logic [LEN_W-1:0]  act_done,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [LEN_W-1:0]  q_len,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              pending
);
    // offsets taken modulo 2^ADDR_W so spans crossing zero still test right
    logic [ADDR_W-1:0] act_off, q_off;
    logic              in_act, in_q;

    always_comb begin
        act_off = qry_addr - (act_addr + ADDR_W'(act_done));
        q_off   = qry_addr - q_addr;
        in_act  = act_valid && (act_off < ADDR_W'(act_len - act_done));
        in_q    = q_valid && (q_off < ADDR_W'(q_len));
        pending = in_act || in_q;
    end
endmodule

// File: rtl/xc_wait_timer.sv
module xc_wait_timer #(
    parameter int TIMEOUT_CYC = 500_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic stall,
    output logic giveup
);
    localparam int CW = $clog2(TIMEOUT_CYC) + 1;

    logic [CW-1:0] cnt_r;

    assign giveup = stall && (cnt_r == CW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_r <= '0;
        else if (stall && !giveup)
            cnt_r <= cnt_r + 1'b1;
        else
            cnt_r <= '0;
    end
endmodule

// File: rtl/xfer_coalescer.sv
module xfer_coalescer
    import xc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int TIMEOUT_CYC = 500_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ack,
    output logic              req_wait,
    output logic              req_giveup,
    input  logic              cons_valid,
    input  logic [LEN_W-1:0]  cons_len,
    output logic [ADDR_W-1:0] cons_addr,
    output logic [LEN_W-1:0]  cons_avail,
    output logic              active,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_pending
);
    dec_e              dec;
    logic              act_valid, q_valid;
    logic [ADDR_W-1:0] act_addr, q_addr;
    logic [LEN_W-1:0]  act_len, act_done, q_len;

    xc_decide #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_decide (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .act_valid (act_valid),
        .act_addr  (act_addr),
        .act_len   (act_len),
        .q_valid   (q_valid),
        .q_addr    (q_addr),
        .q_len     (q_len),
        .dec       (dec)
    );

    xc_slots #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .cons_valid (cons_valid),
        .cons_len   (cons_len),
        .act_valid  (act_valid),
        .act_addr   (act_addr),
        .act_len    (act_len),
        .act_done   (act_done),
        .q_valid    (q_valid),
        .q_addr     (q_addr),
        .q_len      (q_len)
    );

    xc_query #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_query (
        .act_valid (act_valid),
        .act_addr  (act_addr),
        .act_len   (act_len),
        .act_done  (act_done),
        .q_valid   (q_valid),
        .q_addr    (q_addr),
        .q_len     (q_len),
        .qry_addr  (qry_addr),
        .pending   (qry_pending)
    );

    xc_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .stall  (req_wait),
        .giveup (req_giveup)
    );

    assign req_ack    = dec_accepts(dec);
    assign req_wait   = (dec == DEC_WAIT);
    assign active     = act_valid;
    assign cons_addr  = act_valid ? act_addr + ADDR_W'(act_done) : '0;
    assign cons_avail = act_valid ? act_len - act_done : '0;
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ack,
    input logic              req_wait,
    input logic              req_giveup,
    input logic              cons_valid,
    input logic [LEN_W-1:0]  cons_len,
    input logic [ADDR_W-1:0] cons_addr,
    input logic [LEN_W-1:0]  cons_avail,
    input logic              active,
    input logic              qry_pending
);
    // R6
    wait_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_wait |-> (active && !req_ack));

    // R8
    active_has_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cons_avail != '0));

    // R9
    idle_not_pending_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !qry_pending);

    // R10
    giveup_needs_wait_chk: assert property (@(posedge clk) disable iff (rst)
        req_giveup |-> req_wait);

    // R7
    quiet_holds_span_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !cons_valid) |=>
            ($stable(cons_addr) && $stable(cons_avail) && $stable(active)));

    // R7
    consume_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !req_valid && cons_valid && cons_len < cons_avail) |=>
            (cons_addr == $past(cons_addr) + ADDR_W'($past(cons_len))) &&
            (cons_avail == $past(cons_avail) - $past(cons_len)));
endmodule

bind xfer_coalescer xc_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ack     (req_ack),
    .req_wait    (req_wait),
    .req_giveup  (req_giveup),
    .cons_valid  (cons_valid),
    .cons_len    (cons_len),
    .cons_addr   (cons_addr),
    .cons_avail  (cons_avail),
    .active      (active),
    .qry_pending (qry_pending)
);

// File: tb/xfer_coalescer_bench.sv
`timescale 1ns/1ps
module xfer_coalescer_bench;
    localparam int AW = 16;
    localparam int LW = 8;
    localparam int T  = 12;
    localparam int AMASK = 32'hFFFF;
    localparam int LMAX  = 255;

    localparam int D_NONE = 0, D_NULL = 1, D_START = 2, D_GA = 3,
                   D_GQ = 4, D_ENQ = 5, D_WAIT = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic          req_ack, req_wait, req_giveup;
    logic          cons_valid;
    logic [LW-1:0] cons_len;
    logic [AW-1:0] cons_addr;
    logic [LW-1:0] cons_avail;
    logic          active;
    logic [AW-1:0] qry_addr;
    logic          qry_pending;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // reference state
    bit m_av, m_qv;
    int m_aa, m_al, m_ad, m_qa, m_ql, m_wc;

    always #5 clk = ~clk;

    xfer_coalescer #(.ADDR_W(AW), .LEN_W(LW), .TIMEOUT_CYC(T)) u_xfer_coalescer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ack(req_ack), .req_wait(req_wait),
        .req_giveup(req_giveup), .cons_valid(cons_valid), .cons_len(cons_len),
        .cons_addr(cons_addr), .cons_avail(cons_avail), .active(active),
        .qry_addr(qry_addr), .qry_pending(qry_pending)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int exp_dec(bit v, int a, int l);
        if (!v) return D_NONE;
        if (l == 0) return D_NULL;
        if (!m_av) return D_START;
        if (!m_qv && a == ((m_aa + m_al) & AMASK) && m_al + l <= LMAX) return D_GA;
        if (m_qv && a == ((m_qa + m_ql) & AMASK) && m_ql + l <= LMAX) return D_GQ;
        if (!m_qv) return D_ENQ;
        return D_WAIT;
    endfunction

    function automatic bit exp_pend(int q);
        bit pa, pq;
        pa = m_av && (((q - (m_aa + m_ad)) & AMASK) < (m_al - m_ad));
        pq = m_qv && (((q - m_qa) & AMASK) < m_ql);
        return pa || pq;
    endfunction

    function automatic string dec_tag(int d);
        case (d)
            D_START: return "R2";
            D_GA:    return "R3";
            D_GQ:    return "R4";
            D_ENQ:   return "R5";
            D_WAIT:  return "R6";
            D_NULL:  return "R11";
            default: return "R6";
        endcase
    endfunction

    // one cycle: drive after falling edge, check, advance the reference model
    task automatic step(bit v, int a, int l, bit cv, int cl, int qa, output int d);
        int take;
        bit g;
        @(negedge clk);
        req_valid = v; req_addr = AW'(a); req_len = LW'(l);
        cons_valid = cv; cons_len = LW'(cl); qry_addr = AW'(qa);
        #1;
        d = exp_dec(v, a, l);
        g = (d == D_WAIT) && (m_wc == T - 1);
        check(dec_tag(d), {29'd0, req_ack, req_wait, 1'b0},
              {29'd0, d != D_NONE && d != D_WAIT, d == D_WAIT, 1'b0});
        check("R10", req_giveup, g);
        check("R8", active, m_av);
        check("R7", cons_avail, m_av ? m_al - m_ad : 0);
        if (m_av) check("R7", cons_addr, (m_aa + m_ad) & AMASK);
        check("R9", qry_pending, exp_pend(qa));
        if (m_av && cv) begin
            take = (cl > m_al - m_ad) ? m_al - m_ad : cl;
            m_ad += take;
        end
        case (d)
            D_START: begin m_aa = a; m_al = l; m_ad = 0; m_av = 1; end
            D_GA:    m_al += l;
            D_GQ:    m_ql += l;
            D_ENQ:   begin m_qa = a; m_ql = l; m_qv = 1; end
            default: ;
        endcase
        if (m_av && m_ad == m_al) begin
            m_ad = 0;
            if (m_qv) begin m_aa = m_qa; m_al = m_ql; m_qv = 0; end
            else m_av = 0;
        end
        m_wc = (d == D_WAIT && !g) ? m_wc + 1 : 0;
    endtask

    initial begin
        #1_900_000;
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int d, gcount, hold_a, hold_l;
        bit hold;
        void'($urandom(32'h5eed_c0de));
        rst = 1; req_valid = 0; req_addr = 0; req_len = 0;
        cons_valid = 0; cons_len = 0; qry_addr = 0;
        m_av = 0; m_qv = 0; m_aa = 0; m_al = 0; m_ad = 0; m_qa = 0; m_ql = 0; m_wc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        check("R1", active, 0);
        check("R1", cons_avail, 0);
        check("R1", qry_pending, 0);

        // directed corner cases
        step(1, 'h100, 16, 0, 0, 'h100, d);  // R2 start
        step(1, 'h110, 8, 0, 0, 'h117, d);   // R3 grow active
        step(1, 'h200, 4, 0, 0, 'h118, d);   // R5 enqueue
        step(1, 'h204, 4, 0, 0, 'h0FF, d);   // R4 grow queued
        step(0, 0, 0, 0, 0, 'h207, d);
        step(0, 0, 0, 0, 0, 'h208, d);
        // R6 / R10: hold a non-mergeable request until give-up
        gcount = 0;
        for (int i = 0; i < T + 3; i++) begin
            step(1, 'h118, 4, 0, 0, 'h100 + i, d);
            if (req_giveup) gcount = i + 1;
        end
        check("R10", gcount, T);
        step(1, 'h500, 0, 0, 0, 'h500, d);   // R11 zero count
        step(0, 0, 0, 1, 10, 'h109, d);      // R7 partial consume
        step(0, 0, 0, 1, 14, 'h10A, d);      // R8 promote
        step(0, 0, 0, 0, 0, 'h200, d);
        step(1, 'h300, 6, 1, 100, 'h207, d); // R8 request same cycle as drain
        step(0, 0, 0, 1, 100, 'h300, d);
        step(0, 0, 0, 0, 0, 'h300, d);
        step(1, 'h1000, 200, 0, 0, 'h10C7, d);
        step(1, 'h10C8, 100, 0, 0, 'h10C8, d); // R5 merge refused on overflow
        step(1, 'hFFF0, 20, 1, 255, 'h1120, d);
        step(1, 'hFFF0, 20, 1, 255, 'h0002, d); // R9 wrap range
        step(0, 0, 0, 1, 255, 'h0003, d);

        // random traffic
        hold = 0; hold_a = 0; hold_l = 0;
        for (int i = 0; i < 4000; i++) begin
            int k, a, l, qa;
            bit v;
            k = int'($urandom % 8);
            v = 1;
            if (hold && ($urandom % 4) != 0) begin
                a = hold_a; l = hold_l;
            end else begin
                l = 1 + int'($urandom % 40);
                case (k)
                    0, 1: begin v = 0; a = 0; end
                    2: a = (m_aa + m_al) & AMASK;
                    3: a = (m_qa + m_ql) & AMASK;
                    4: begin a = int'($urandom & AMASK); l = 0; end
                    default: a = int'($urandom & AMASK);
                endcase
            end
            qa = (($urandom % 2) == 0) ? ((m_aa + int'($urandom % 72) - 8) & AMASK)
                                       : ((m_qa + int'($urandom % 48) - 4) & AMASK);
            step(v, a, l, ($urandom % 3) != 0, int'($urandom % 24), qa, d);
            hold = (d == D_WAIT) && !req_giveup;
            hold_a = a; hold_l = l;
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule